// File: doc/BRIEF.md
# Gray-Shadowed Pointer Unit for a Dual-Clock Queue

This block keeps one side's pointer of a queue whose two sides run on unrelated clocks. The pointer is counted in plain binary, so local address arithmetic needs no decoding. A second register counts in lock-step and holds the Gray-coded form of the pointer, for export to the other clock domain. That register does not decode the binary outputs. Its D input is the Gray conversion of the binary counter's next value, so both registers change on the same edge. The Gray output then never shows the short multi-bit transients that a decode of a changing binary value would pass on.

The other domain's Gray pointer enters through a chain of synchronizer flops. It is then compared with the local Gray pointer by identity alone. One parameter selects the side. The read side raises its flag (empty) when the two pointers match exactly. The write side raises its flag (full) when they match except that the two most significant Gray bits are inverted. Pointers carry one wrap bit above the address width. The pointer moves only when an increment is requested and the side's flag is low.

Top module: `gptr_unit`

## Requirements
- R1: While `rst_n` is low, at each clock edge `bin_ptr`, `gray_ptr` and every synchronizer stage return to zero.
- R2: When `inc_en` is high and `flag` is low at a clock edge, `bin_ptr` becomes its previous value plus one, modulo 2^(ADDR_W+1).
- R3: In every cycle, `gray_ptr` equals `bin_ptr ^ (bin_ptr >> 1)`, with no lag between the two.
- R4: At each increment exactly one bit of `gray_ptr` changes. When the pointer does not move, no bit changes. This holds across a full wrap of the pointer.
- R5: With `FULL_SIDE = 0`, `flag` is high exactly when `gray_ptr` equals the synchronized remote Gray pointer.
- R6: With `FULL_SIDE = 1`, `flag` is high exactly when `gray_ptr` equals the synchronized remote pointer with its two most significant bits inverted, and all lower bits equal.
- R7: When `flag` is high, `inc_en` has no effect: `bin_ptr` and `gray_ptr` hold.
- R8: A value placed on `remote_gray` before clock edge k is used by the comparison after edge k+SYNC_STAGES-1 (with the default of 2 stages, after the second edge).
- R9: When `inc_en` is low, `bin_ptr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_en | input | 1 | Request to advance the pointer by one |
| remote_gray | input | ADDR_W+1 | Gray pointer from the other clock domain, not yet synchronized |
| bin_ptr | output | ADDR_W+1 | Local binary pointer, including the wrap bit |
| gray_ptr | output | ADDR_W+1 | Registered Gray form of the local pointer |
| flag | output | 1 | Empty (read side) or full (write side) |

## Verification
On every cycle, the bound checker tests four things. The Gray output must match the binary pointer. At most one Gray bit may change per edge. Each step must be exactly plus one when advancing. The pointer must hold when it is idle or blocked by the flag. Three behaviours come only from the bench scenarios, which track a model of the synchronizer pipeline. These are the latency of a remote pointer change through the synchronizer, the exact empty and full decode on each side, and a complete wrap in which the write side follows a moving remote pointer.

// File: rtl/gptr_pkg.sv
// Package: shared helpers for the Gray-shadowed pointer unit.
// Assumes pointer widths are at least 2 bits (one address bit plus wrap).
package gptr_pkg;

    // Binary to Gray: each output bit is the XOR of two adjacent input bits.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/gptr_sync.sv
// Module: multi-stage synchronizer for a Gray-coded bus.
// Assumes the source changes at most one bit per source clock, so any
// sampled value is either the old or the new pointer.
module gptr_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous bus.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages give a metastable first stage time to settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gptr_counter.sv
// Module: binary pointer with a parallel Gray register.
// The Gray register loads the conversion of the binary next-state value,
// so both registers change on the same edge and the Gray output never
// carries decode transients. Assumes WIDTH >= 2.
module gptr_counter #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [WIDTH-1:0] bin_q,
    output logic [WIDTH-1:0] gray_q
);
    import gptr_pkg::*;

    logic [WIDTH-1:0] bin_d;
    logic [31:0]      gray_wide;

    // Next-state value of the binary counter.
    always_comb begin
        bin_d = bin_q + {{(WIDTH-1){1'b0}}, advance};
    end

    // Gray of the D inputs, one XOR level deep whatever the width.
    assign gray_wide = to_gray(32'(bin_d));

    // Both registers update on the same edge, in step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= gray_wide[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/gptr_cmp.sv
// Module: identity compare of local and synchronized Gray pointers.
// FULL_SIDE picks the decode: 0 gives empty (exact match), 1 gives full
// (top two bits inverted, the rest equal). Assumes WIDTH >= 2.
module gptr_cmp #(
    parameter int WIDTH     = 5,
    parameter bit FULL_SIDE = 1'b0
) (
    input  logic [WIDTH-1:0] local_gray,
    input  logic [WIDTH-1:0] remote_gray,
    output logic             hit
);
    localparam logic [WIDTH-1:0] TOP2 = {2'b11, {(WIDTH-2){1'b0}}};

    generate
        if (FULL_SIDE) begin : g_full
            // Full: the writer is one wrap ahead of the reader.
            assign hit = (local_gray == (remote_gray ^ TOP2));
        end else begin : g_empty
            // Empty: both pointers identical.
            assign hit = (local_gray == remote_gray);
        end
    endgenerate
endmodule

// File: rtl/gptr_unit.sv
// Module: one side of a dual-clock queue pointer pair.
// Counts in binary, exports Gray, synchronizes the remote Gray pointer
// and derives empty or full. Assumes remote_gray changes one bit at a time.
module gptr_unit #(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit FULL_SIDE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [ADDR_W:0]   remote_gray,
    output logic [ADDR_W:0]   bin_ptr,
    output logic [ADDR_W:0]   gray_ptr,
    output logic              flag
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] remote_sync;
    logic             advance;

    // The pointer moves only on a request the flag does not block.
    assign advance = inc_en & ~flag;

    gptr_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (remote_gray),
        .q_sync  (remote_sync)
    );

    gptr_counter #(.WIDTH(PTR_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .bin_q   (bin_ptr),
        .gray_q  (gray_ptr)
    );

    gptr_cmp #(.WIDTH(PTR_W), .FULL_SIDE(FULL_SIDE)) u_cmp (
        .local_gray  (gray_ptr),
        .remote_gray (remote_sync),
        .hit         (flag)
    );
endmodule

// File: rtl/gptr_unit_chk.sv
// Module: assertion checker for gptr_unit, attached with bind.
// Assumes it sees the top module's ports only.
module gptr_unit_chk #(
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inc_en,
    input logic             flag,
    input logic [PTR_W-1:0] bin_ptr,
    input logic [PTR_W-1:0] gray_ptr
);
    // R1: reset clears both pointer registers
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (bin_ptr == '0 && gray_ptr == '0));

    // R2: an unblocked request steps by exactly one
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !flag) |=> (bin_ptr == $past(bin_ptr) + 1'b1));

    // R3: Gray register tracks the binary register with no lag
    p_gray_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gray_ptr == (bin_ptr ^ (bin_ptr >> 1)));

    // R4: never more than one Gray bit flips per edge
    p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_ptr ^ $past(gray_ptr)) <= 1);

    // R7: a raised flag blocks the request
    p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && flag) |=> $stable(bin_ptr));

    // R9: no request, no movement
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_en |=> $stable(bin_ptr));
endmodule

bind gptr_unit gptr_unit_chk #(.PTR_W(ADDR_W + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (inc_en),
    .flag     (flag),
    .bin_ptr  (bin_ptr),
    .gray_ptr (gray_ptr)
);

// File: tb/tb_gptr_unit.sv
// Bench: read-side (dut) and write-side (dut_w) instances. A driver task
// pushes predicted results into queues and a monitor compares them.
module tb_gptr_unit;
    localparam int AW = 4;
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          flag;
        logic          moved;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc_r = 1'b0, inc_w = 1'b0;
    logic [PW-1:0] rem_r = '0, rem_w = '0;
    logic [PW-1:0] bin_r, gray_r, bin_w, gray_w;
    logic          flag_r, flag_w;

    int checks = 0;
    int fails  = 0;

    exp_t q_r[$];
    exp_t q_w[$];

    // Bench model state, built from the requirements.
    logic [PW-1:0] mb_r = '0, mb_w = '0;
    logic [PW-1:0] pr0 = '0, pr1 = '0, pw0 = '0, pw1 = '0;
    logic [PW-1:0] prev_gr = '0, prev_gw = '0;
    event          sample_ev;

    always #4 clk = ~clk;   // 125 MHz

    gptr_unit #(.ADDR_W(AW), .SYNC_STAGES(2), .FULL_SIDE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_r), .remote_gray(rem_r),
        .bin_ptr(bin_r), .gray_ptr(gray_r), .flag(flag_r));

    gptr_unit #(.ADDR_W(AW), .SYNC_STAGES(2), .FULL_SIDE(1'b1)) dut_w (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_w), .remote_gray(rem_w),
        .bin_ptr(bin_w), .gray_ptr(gray_w), .flag(flag_w));

    function automatic logic [PW-1:0] g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic empty_of(input logic [PW-1:0] lb, input logic [PW-1:0] rg);
        return g(lb) == rg;
    endfunction

    function automatic logic full_of(input logic [PW-1:0] lb, input logic [PW-1:0] rg);
        return g(lb) == (rg ^ {2'b11, {(PW-2){1'b0}}});
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the predicted result.
    task automatic step(input logic ir, input logic iw,
                        input logic [PW-1:0] rr, input logic [PW-1:0] rw);
        exp_t er, ew;
        logic ar, aw;
        @(negedge clk);
        inc_r = ir; inc_w = iw; rem_r = rr; rem_w = rw;
        ar = ir & ~empty_of(mb_r, pr1);   // R7: blocked while flag high
        aw = iw & ~full_of(mb_w, pw1);
        mb_r = mb_r + PW'(ar);            // R2
        mb_w = mb_w + PW'(aw);
        pr1 = pr0; pr0 = rr;              // R8: two-stage pipeline
        pw1 = pw0; pw0 = rw;
        er = '{bin: mb_r, gray: g(mb_r), flag: empty_of(mb_r, pr1), moved: ar};
        ew = '{bin: mb_w, gray: g(mb_w), flag: full_of(mb_w, pw1), moved: aw};
        q_r.push_back(er);
        q_w.push_back(ew);
        @(posedge clk);
        #1;
        -> sample_ev;
    endtask

    // Monitor: compare design outputs with the queued predictions.
    always @(sample_ev) begin
        exp_t er, ew;
        if (q_r.size() > 0 && q_w.size() > 0) begin
            er = q_r.pop_front();
            ew = q_w.pop_front();
            check("R2/R9 read bin", bin_r, er.bin);
            check("R2/R9 write bin", bin_w, ew.bin);
            check("R3 read gray", gray_r, g(bin_r));
            check("R3 write gray", gray_w, g(bin_w));
            check("R5 empty flag", PW'(flag_r), PW'(er.flag));
            check("R6 full flag", PW'(flag_w), PW'(ew.flag));
            check("R4 read gray bits changed", PW'($countones(gray_r ^ prev_gr)), PW'(er.moved));
            check("R4 write gray bits changed", PW'($countones(gray_w ^ prev_gw)), PW'(ew.moved));
            prev_gr = gray_r;
            prev_gw = gray_w;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [PW-1:0] j;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 read bin reset", bin_r, '0);
        check("R1 write bin reset", bin_w, '0);
        check("R1 read gray reset", gray_r, '0);
        check("R1 empty at reset", PW'(flag_r), PW'(1'b1));
        check("R1 full clear at reset", PW'(flag_w), PW'(1'b0));
        @(negedge clk);
        rst_n = 1'b1;

        // R7: read side empty, requests ignored; R9 idle holds
        repeat (3) step(1'b1, 1'b0, '0, '0);
        // R8: remote read pointer jumps to five, seen after two edges
        step(1'b0, 1'b0, g(PW'(5)), '0);
        step(1'b0, 1'b0, g(PW'(5)), '0);
        // R2, R5: drain to empty, then blocked
        repeat (7) step(1'b1, 1'b0, g(PW'(5)), '0);
        // R6: write side fills at sixteen, then blocked (R7)
        repeat (20) step(1'b0, 1'b1, g(PW'(5)), '0);
        // R4: full wrap on both sides with moving remote pointers
        for (int k = 0; k < 40; k++) begin
            j = PW'(k + 6);
            step(1'b1, 1'b1, g(j), g(PW'(k + 1)));
        end
        // Mixed request pattern
        for (int k = 0; k < 12; k++) begin
            step(k[0], k[1], g(PW'(46)), g(PW'(40)));
        end

        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule